// File: doc/BRIEF.md
# Legacy Peripheral Configuration Unlock Controller

This block watches byte writes on a simple I/O bus (address, write data, write strobe, read strobe). It looks for a two-stage key before it opens the configuration space of a legacy peripheral controller. The first stage is a short key on a fixed port. Its last two bytes choose one of three base addresses. The second stage is a 32-byte pseudo-random key written to that base. Once both stages match, the block is in configuration mode.

In configuration mode, an index port at the base address and a data port at base+1 give access to a small register file. This file holds global registers: a logical-device selector, a clock-select bit and a suspend bit. It also holds an activation bit for each logical device, banked by the device selector. Writing the exit code to the control register locks the block again. The outputs drive the device activation bits, the clock select and the suspend control. They keep their values while the block is locked.

Top module: `sio_cfg_unlock`

## Requirements
- R1: After reset the block is locked (`cfg_mode_o`=0), `base_sel_o`=0 (no base), and `dev_en_o`, `clk_sel_o` and `susp_o` are all 0.
- R2: Stage one is four writes to port 0x0279: 0x86, 0x80, then selector bytes A and B. A,B = 0x55,0x55 gives `base_sel_o`=1 (base 0x3F0). A,B = 0x55,0xAA gives 2 (base 0x3BD). A,B = 0xAA,0x55 gives 3 (base 0x370). Any other pair leaves the block at 0.
- R3: Stage two is 32 writes to the selected base. The first byte is 0x6A. Each following byte is the previous one shifted right by one bit, with bit 7 set to bit0 XOR bit1 of the previous byte. The last matching byte sets `cfg_mode_o` in the cycle after its write. Before that, `cfg_mode_o` stays 0.
- R4: In stage one, a byte to 0x0279 that does not match returns the detector to its start. In that case a 0x86 counts again as the first key byte. In stage two, a wrong byte at the base returns the block to locked with `base_sel_o`=0. Writes to 0x0279 during stage two are ignored.
- R5: In configuration mode, a write to the base address sets the index. A read of the base returns the index. Data port reads and writes at base+1 act on the indexed register.
- R6: Register 0x07 holds an 8-bit logical device number, readable back. Register 0x30 bit 0 is the activation bit of the selected device. Device number 1 drives `dev_en_o[0]` and number 2 drives `dev_en_o[1]`. A write to 0x30 for any other device number changes nothing, and it reads back 0x00.
- R7: Register 0x23 bit 0 drives `clk_sel_o`. Register 0x24 bit 0 drives `susp_o`. Both read back in bit 0, with the other bits 0.
- R8: Writing 0x02 to register 0x02 leaves configuration mode. After this `cfg_mode_o`=0 and `base_sel_o`=0. Any other value written to register 0x02 has no effect. Register 0x02 reads 0xFF.
- R9: While locked, writes to the index and data ports change nothing, and all reads return 0xFF.
- R10: Register contents and outputs are retained across exit from and re-entry into configuration mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 16 | I/O address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, 0xFF when not decoded |
| cfg_mode_o | output | 1 | Configuration mode active |
| base_sel_o | output | 2 | Selected base: 0 none, 1 0x3F0, 2 0x3BD, 3 0x370 |
| dev_en_o | output | NUM_DEV | Activation bit per logical device |
| clk_sel_o | output | 1 | Input clock select (0 = 24 MHz) |
| susp_o | output | 1 | Software suspend (0 = running) |

## Verification
The assertions check four things on every cycle. Configuration mode starts only right after the final key byte is accepted. The exit write always locks the block. Locked state freezes the register outputs and forces reads to 0xFF. An index write always lands in the index. The remaining behaviour can only be shown by the bench's scenarios: which selector pair picks which base, a restart after a wrong key byte, 0x0279 writes interleaved into stage two, bank selection through the device number, and state kept across re-entry.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [15:0] KEY_PORT  = 16'h0279;
  localparam int          KEY_LEN   = 32;
  localparam logic [7:0]  KEY_SEED  = 8'h6A;
  localparam logic [7:0]  K1_BYTE   = 8'h86;
  localparam logic [7:0]  K2_BYTE   = 8'h80;
  localparam logic [7:0]  SEL_LO    = 8'h55;
  localparam logic [7:0]  SEL_HI    = 8'hAA;

  localparam logic [7:0]  REG_CTRL  = 8'h02;
  localparam logic [7:0]  REG_LDN   = 8'h07;
  localparam logic [7:0]  REG_CLK   = 8'h23;
  localparam logic [7:0]  REG_SUSP  = 8'h24;
  localparam logic [7:0]  REG_ACT   = 8'h30;
  localparam logic [7:0]  EXIT_CODE = 8'h02;

  typedef enum logic [1:0] {BASE_NONE, BASE_3F0, BASE_3BD, BASE_370} base_e;

  function automatic logic [7:0] key_byte(input int n);
    logic [7:0] b;
    b = KEY_SEED;
    for (int i = 0; i < n; i++) b = {b[0] ^ b[1], b[7:1]};
    return b;
  endfunction

  function automatic logic [15:0] base_addr(input base_e s);
    case (s)
      BASE_3F0: return 16'h03F0;
      BASE_3BD: return 16'h03BD;
      BASE_370: return 16'h0370;
      default:  return 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_detect.sv
module sio_key_detect
  import sio_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        exit_i,
  output logic        cfg_mode_o,
  output base_e       base_o
);
  localparam int CW = $clog2(KEY_LEN);

  typedef enum logic [2:0] {ST_IDLE, ST_K1, ST_K2, ST_K3, ST_KEY, ST_CFG} st_e;

  st_e           st_q;
  logic          sel_hi_q;
  base_e         base_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    key_tab [KEY_LEN];

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
    assign key_tab[g] = key_byte(g);
  end

  wire  port_wr = wr_i && (addr_i == KEY_PORT);
  wire  base_wr = wr_i && (addr_i == base_addr(base_q));
  st_e  restart;
  base_e sel_base;

  assign restart = (wdata_i == K1_BYTE) ? ST_K1 : ST_IDLE;

  always_comb begin
    sel_base = BASE_NONE;
    if (!sel_hi_q && wdata_i == SEL_LO) sel_base = BASE_3F0;
    if (!sel_hi_q && wdata_i == SEL_HI) sel_base = BASE_3BD;
    if ( sel_hi_q && wdata_i == SEL_LO) sel_base = BASE_370;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      sel_hi_q <= 1'b0;
      base_q   <= BASE_NONE;
      cnt_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (port_wr && wdata_i == K1_BYTE) st_q <= ST_K1;
        ST_K1: if (port_wr) st_q <= (wdata_i == K2_BYTE) ? ST_K2 : restart;
        ST_K2: if (port_wr) begin
          if (wdata_i == SEL_LO || wdata_i == SEL_HI) begin
            st_q     <= ST_K3;
            sel_hi_q <= (wdata_i == SEL_HI);
          end else st_q <= restart;
        end
        ST_K3: if (port_wr) begin
          if (sel_base != BASE_NONE) begin
            st_q   <= ST_KEY;
            base_q <= sel_base;
            cnt_q  <= '0;
          end else st_q <= restart;
        end
        ST_KEY: if (base_wr) begin
          if (wdata_i != key_tab[cnt_q]) begin
            st_q   <= ST_IDLE;
            base_q <= BASE_NONE;
          end else if (cnt_q == CW'(KEY_LEN - 1)) st_q <= ST_CFG;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_CFG: if (exit_i) begin
          st_q   <= ST_IDLE;
          base_q <= BASE_NONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_mode_o = (st_q == ST_CFG);
  assign base_o     = base_q;

  // R3
  key_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past(st_q == ST_KEY && cnt_q == CW'(KEY_LEN - 1)));
  // R8
  exit_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && cfg_mode_o) |=> (!cfg_mode_o && base_o == BASE_NONE));
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV   = 2,
  parameter int FIRST_LDN = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_i,
  input  logic               idx_wr_i,
  input  logic               dat_wr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         idx_o,
  output logic [7:0]         rd_data_o,
  output logic               exit_o,
  output logic [NUM_DEV-1:0] dev_en_o,
  output logic               clk_sel_o,
  output logic               susp_o
);
  logic [7:0]         idx_q, ldn_q;
  logic               clk_q, susp_q;
  logic [NUM_DEV-1:0] act_q, dev_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      ldn_q  <= '0;
      clk_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      if (idx_wr_i) idx_q <= wdata_i;
      if (dat_wr_i) begin
        case (idx_q)
          REG_LDN:  ldn_q  <= wdata_i;
          REG_CLK:  clk_q  <= wdata_i[0];
          REG_SUSP: susp_q <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign dev_hit[g] = (ldn_q == 8'(FIRST_LDN + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q[g] <= 1'b0;
      else if (dat_wr_i && idx_q == REG_ACT && dev_hit[g]) act_q[g] <= wdata_i[0];
    end
  end

  always_comb begin
    case (idx_q)
      REG_CTRL: rd_data_o = 8'hFF;
      REG_LDN:  rd_data_o = ldn_q;
      REG_CLK:  rd_data_o = {7'b0, clk_q};
      REG_SUSP: rd_data_o = {7'b0, susp_q};
      REG_ACT:  rd_data_o = {7'b0, |(act_q & dev_hit)};
      default:  rd_data_o = 8'h00;
    endcase
  end

  assign exit_o    = dat_wr_i && idx_q == REG_CTRL && wdata_i == EXIT_CODE;
  assign idx_o     = idx_q;
  assign dev_en_o  = act_q;
  assign clk_sel_o = clk_q;
  assign susp_o    = susp_q;

  // R9
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i |=> $stable({act_q, clk_q, susp_q, ldn_q}));
  // R5
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> idx_q == $past(wdata_i));
endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV   = 2,
  parameter int FIRST_LDN = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [15:0]        addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               cfg_mode_o,
  output logic [1:0]         base_sel_o,
  output logic [NUM_DEV-1:0] dev_en_o,
  output logic               clk_sel_o,
  output logic               susp_o
);
  logic       cfg, exit_w;
  base_e      base;
  logic [7:0] idx, reg_rd;
  logic [15:0] idx_addr;

  assign idx_addr = base_addr(base);
  wire idx_hit = cfg && addr_i == idx_addr;
  wire dat_hit = cfg && addr_i == idx_addr + 16'd1;

  sio_key_detect u_det (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .exit_i(exit_w), .cfg_mode_o(cfg), .base_o(base)
  );

  sio_cfg_regs #(.NUM_DEV(NUM_DEV), .FIRST_LDN(FIRST_LDN)) u_regs (
    .clk_i, .rst_ni, .cfg_i(cfg),
    .idx_wr_i(wr_i && idx_hit), .dat_wr_i(wr_i && dat_hit), .wdata_i,
    .idx_o(idx), .rd_data_o(reg_rd), .exit_o(exit_w),
    .dev_en_o, .clk_sel_o, .susp_o
  );

  always_comb begin
    rdata_o = 8'hFF;
    if (rd_i && idx_hit) rdata_o = idx;
    if (rd_i && dat_hit) rdata_o = reg_rd;
  end

  assign cfg_mode_o = cfg;
  assign base_sel_o = base;

  // R9
  locked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |-> rdata_o == 8'hFF);
endmodule

// File: tb/sio_cfg_unlock_tb.sv
module sio_cfg_unlock_tb;
  localparam int ND = 2;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic        cfg_mode, clk_sel, susp;
  logic [1:0]  base_sel;
  logic [ND-1:0] dev_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_cfg_unlock #(.NUM_DEV(ND)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cfg_mode_o(cfg_mode),
    .base_sel_o(base_sel), .dev_en_o(dev_en), .clk_sel_o(clk_sel), .susp_o(susp)
  );

  typedef enum {K_RD, K_CFG, K_BASE, K_EN, K_CLK, K_SUSP} kind_e;
  typedef struct { kind_e kind; logic [7:0] exp; string req; } item_t;
  item_t sb_q[$];
  event smp_ev;

  // monitor: pops expected items and compares them with the ports
  always @(smp_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:   act = rdata;
        K_CFG:  act = {7'b0, cfg_mode};
        K_BASE: act = {6'b0, base_sel};
        K_EN:   act = {{(8-ND){1'b0}}, dev_en};
        K_CLK:  act = {7'b0, clk_sel};
        default: act = {7'b0, susp};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s: actual %02h expected %02h", it.req, it.kind.name(), act, it.exp);
      end
    end
  end

  task automatic expect_val(kind_e k, logic [7:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic sample();
    #2 -> smp_ev;
    #1;
  endtask

  task automatic io_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic io_rd(logic [15:0] a, logic [7:0] e, string r);
    @(negedge clk); rd = 1'b1; addr = a;
    expect_val(K_RD, e, r);
    sample();
    rd = 1'b0;
  endtask

  task automatic chk(kind_e k, logic [7:0] e, string r);
    expect_val(k, e, r);
    sample();
  endtask

  function automatic logic [7:0] kb(int n);
    logic [7:0] b = 8'h6A;
    for (int i = 0; i < n; i++) b = {b[0] ^ b[1], b[7:1]};
    return b;
  endfunction

  task automatic stage1(logic [7:0] a, logic [7:0] b);
    io_wr(16'h0279, 8'h86); io_wr(16'h0279, 8'h80);
    io_wr(16'h0279, a);     io_wr(16'h0279, b);
  endtask

  task automatic reg_wr(logic [15:0] base, logic [7:0] idx, logic [7:0] d);
    io_wr(base, idx); io_wr(base + 16'd1, d);
  endtask

  task automatic reg_rd(logic [15:0] base, logic [7:0] idx, logic [7:0] e, string r);
    io_wr(base, idx); io_rd(base + 16'd1, e, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(K_CFG, 0, "R1"); chk(K_BASE, 0, "R1"); chk(K_EN, 0, "R1");
    chk(K_CLK, 0, "R1"); chk(K_SUSP, 0, "R1");
    rst_n = 1'b1;
    io_rd(16'h03F1, 8'hFF, "R9");

    // unlock at 0x3F0
    stage1(8'h55, 8'h55);
    chk(K_BASE, 1, "R2");
    for (int i = 0; i < 31; i++) io_wr(16'h03F0, kb(i));
    chk(K_CFG, 0, "R3");
    io_wr(16'h03F0, kb(31));
    chk(K_CFG, 1, "R3");

    // banked device registers
    io_wr(16'h03F0, 8'h07);
    io_rd(16'h03F0, 8'h07, "R5");
    io_wr(16'h03F1, 8'h01);
    io_rd(16'h03F1, 8'h01, "R6");
    reg_wr(16'h03F0, 8'h30, 8'h01);
    chk(K_EN, 8'h01, "R6");
    reg_wr(16'h03F0, 8'h07, 8'h02);
    reg_wr(16'h03F0, 8'h30, 8'h01);
    chk(K_EN, 8'h03, "R6");
    reg_wr(16'h03F0, 8'h07, 8'h05);
    reg_wr(16'h03F0, 8'h30, 8'h00);
    chk(K_EN, 8'h03, "R6");
    io_rd(16'h03F1, 8'h00, "R6");
    reg_wr(16'h03F0, 8'h07, 8'h01);
    reg_wr(16'h03F0, 8'h30, 8'h00);
    chk(K_EN, 8'h02, "R6");
    io_rd(16'h03F1, 8'h00, "R6");

    // clock select and suspend
    reg_wr(16'h03F0, 8'h23, 8'h01);
    chk(K_CLK, 1, "R7");
    reg_wr(16'h03F0, 8'h24, 8'hFF);
    chk(K_SUSP, 1, "R7");
    io_rd(16'h03F1, 8'h01, "R7");

    // exit control
    reg_wr(16'h03F0, 8'h02, 8'h05);
    chk(K_CFG, 1, "R8");
    io_rd(16'h03F1, 8'hFF, "R8");
    io_wr(16'h03F1, 8'h02);
    chk(K_CFG, 0, "R8"); chk(K_BASE, 0, "R8");

    // locked: ports ignore traffic
    io_wr(16'h03F0, 8'h30);
    io_wr(16'h03F1, 8'h01);
    io_wr(16'h03F0, 8'h23);
    io_wr(16'h03F1, 8'h00);
    chk(K_EN, 8'h02, "R9"); chk(K_CLK, 1, "R9");
    io_rd(16'h03F0, 8'hFF, "R9");

    // base 0x370 with a wrong key byte, then a clean pass with port writes interleaved
    stage1(8'hAA, 8'h55);
    chk(K_BASE, 3, "R2");
    for (int i = 0; i < 5; i++) io_wr(16'h0370, kb(i));
    io_wr(16'h0370, kb(5) ^ 8'h01);
    chk(K_BASE, 0, "R4"); chk(K_CFG, 0, "R4");
    stage1(8'hAA, 8'h55);
    for (int i = 0; i < 32; i++) begin
      if (i % 8 == 3) io_wr(16'h0279, 8'h00);
      io_wr(16'h0370, kb(i));
    end
    chk(K_CFG, 1, "R4");
    reg_rd(16'h0370, 8'h23, 8'h01, "R10");
    chk(K_EN, 8'h02, "R10"); chk(K_SUSP, 1, "R10");
    reg_rd(16'h0370, 8'h07, 8'h01, "R10");
    reg_wr(16'h0370, 8'h02, 8'h02);
    chk(K_CFG, 0, "R8");

    // stage-one restart on repeated lead byte, base 0x3BD
    io_wr(16'h0279, 8'h86);
    stage1(8'h55, 8'hAA);
    chk(K_BASE, 2, "R4");
    for (int i = 0; i < 32; i++) io_wr(16'h03BD, kb(i));
    chk(K_CFG, 1, "R3");
    reg_rd(16'h03BD, 8'h30, 8'h00, "R5");
    reg_wr(16'h03BD, 8'h02, 8'h02);
    chk(K_CFG, 0, "R8");

    // invalid selector pair
    stage1(8'hAA, 8'hAA);
    chk(K_BASE, 0, "R2");
    io_wr(16'h03F0, kb(0));
    chk(K_CFG, 0, "R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule